// File: doc/BRIEF.md
# Partial-Word Load/Store Byte Merger

This unit forms the data for big-endian unaligned partial accesses. It covers four operations: left and right loads, and left and right stores. Each operation works on a 4-byte word or an 8-byte doubleword. A load takes the aligned memory data and splices part of it into the old register value. A store takes part of the register value and splices it into the aligned memory data. For a store the unit also returns the write data, a byte-enable mask and the aligned address to write back to.

The merge logic is combinational. One registered stage with a synchronous active-low reset holds the response. The response appears one clock after a request. Address translation, memory timing and faults all belong to the surrounding pipeline. Partial accesses never fault on misalignment.

A 4-byte word sits in bits [31:0] of the data inputs and outputs. Byte 0 of a word, in big-endian order, is its most significant byte. The offset o is the request address modulo the access size S, where S is 4 or 8. Shifts are in bytes.

Top module: `umerge_unit`

## Requirements
- R1: `rsp_addr` is the request address with its low 2 bits cleared for a word and its low 3 bits cleared for a doubleword.
- R2: Load-left (`req_op`=00) shifts memory left by 8·o bits. Register bytes covered by all-ones<<8·o take the shifted memory bytes. The other register bytes keep their old value.
- R3: Load-right (`req_op`=01) uses k = (o XOR (S−1)). It shifts memory right by 8·k bits and fills the lanes of all-ones>>8·k. The remaining register bytes are kept.
- R4: Store-left (`req_op`=10) shifts the register right by 8·o bits into the lanes of all-ones>>8·o. The other memory bytes are unchanged.
- R5: Store-right (`req_op`=11) uses k = (o XOR (S−1)). It shifts the register left by 8·k bits into the lanes of all-ones<<8·k. The other memory bytes are unchanged.
- R6: A word load sign-extends the merged 32-bit result: bits [63:32] of `rsp_reg` all equal bit 31.
- R7: For a store, `rsp_be[i]` is 1 exactly when byte lane i (bits 8i+7..8i) is taken from the register. A word store has `rsp_be[7:4]`=0 and `rsp_wdata[63:32]`=0.
- R8: A load response has `rsp_wdata`=0 and `rsp_be`=0. A store response has `rsp_reg`=0.
- R9: A request with `req_vld`=1 gives `rsp_vld`=1 one clock later. An idle cycle or a reset cycle drives every output to 0 on the next clock.
- R10: At word width, bits [63:32] of `req_mem` and `req_reg` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: bit 1 store, bit 0 right-hand variant |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_addr | input | ADDR_W | Unaligned request address |
| req_mem | input | DATA_W | Aligned memory data |
| req_reg | input | DATA_W | Register value |
| rsp_vld | output | 1 | Response valid |
| rsp_reg | output | DATA_W | Merged register result for loads |
| rsp_wdata | output | DATA_W | Merged memory write data for stores |
| rsp_be | output | DATA_W/8 | Store byte enables, bit i for lane i |
| rsp_addr | output | ADDR_W | Aligned access address |

## Verification
The assertions assume that `req_op` and `req_dword` are known whenever `req_vld` is high. They also assume that reset is held from time zero, so every property is judged against the previous cycle's request.

The stimulus drives new inputs only on falling edges. It keeps every field fully defined and fills the unused upper halves at word width with random data. It sweeps every offset at both widths, for all four operations and three data patterns.

// File: rtl/umerge_pkg.sv
// Shared definitions for the partial-word merge unit.
// Assumes op bit 1 selects a store and op bit 0 selects the right-hand variant.
package umerge_pkg;

    typedef enum logic [1:0] {
        MOP_LOAD_HI  = 2'b00,
        MOP_LOAD_LO  = 2'b01,
        MOP_STORE_HI = 2'b10,
        MOP_STORE_LO = 2'b11
    } merge_op_e;

    function automatic logic op_is_store(input merge_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_right(input merge_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/umerge_lane_ctl.sv
// Derives the shift amount, the shift direction and the lane masks from the
// operation, width and address offset. Assumes DATA_W is a power of two of
// at least 16 bits; a word is the lower half of DATA_W.
module umerge_lane_ctl
    import umerge_pkg::*;
#(
    parameter  int DATA_W = 64,
    localparam int NB     = DATA_W / 8,
    localparam int OFS_W  = $clog2(NB),
    localparam int SH_W   = $clog2(DATA_W),
    localparam int HALF   = DATA_W / 2
) (
    input  merge_op_e         op,
    input  logic              dword,
    input  logic [OFS_W-1:0]  ofs,
    output logic [OFS_W-1:0]  size_m1,
    output logic [SH_W-1:0]   shift_amt,
    output logic              to_left,
    output logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] merge_mask
);

    logic [OFS_W-1:0] eff_ofs;

    // Byte offset, mirrored for right-hand variants, turned into masks.
    always_comb begin
        size_m1    = dword ? OFS_W'(NB - 1) : OFS_W'(NB / 2 - 1);
        eff_ofs    = (ofs ^ (op_is_right(op) ? size_m1 : '0)) & size_m1;
        shift_amt  = SH_W'({eff_ofs, 3'b000});
        to_left    = (op_is_store(op) == op_is_right(op));
        lane_mask  = dword ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
        merge_mask = (to_left ? (lane_mask << shift_amt) : (lane_mask >> shift_amt))
                     & lane_mask;
    end

endmodule

// File: rtl/umerge_datapath.sv
// Shifts the source operand into place and merges it with the kept operand
// under the merge mask; sign-extends a word result on request.
// Assumes merge_mask is already confined to lane_mask.
module umerge_datapath #(
    parameter  int DATA_W = 64,
    localparam int SH_W   = $clog2(DATA_W),
    localparam int HALF   = DATA_W / 2
) (
    input  logic [DATA_W-1:0] keep_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic [DATA_W-1:0] merge_mask,
    input  logic [SH_W-1:0]   shift_amt,
    input  logic              to_left,
    input  logic              sext_word,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] src_lane;
    logic [DATA_W-1:0] moved;
    logic [DATA_W-1:0] merged;

    // Shift the source into place, then combine with the untouched bytes.
    always_comb begin
        src_lane = src_val & lane_mask;
        moved    = (to_left ? (src_lane << shift_amt) : (src_lane >> shift_amt)) & lane_mask;
        merged   = (keep_val & lane_mask & ~merge_mask) | moved;
        result   = sext_word ? {{HALF{merged[HALF-1]}}, merged[HALF-1:0]} : merged;
    end

endmodule

// File: rtl/umerge_byte_en.sv
// Collapses a byte-granular lane mask into one enable bit per byte.
// Assumes each byte of the mask is either all ones or all zeros.
module umerge_byte_en #(
    parameter  int DATA_W = 64,
    localparam int NB     = DATA_W / 8
) (
    input  logic              enable,
    input  logic [DATA_W-1:0] mask,
    output logic [NB-1:0]     be
);

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign be[i] = enable & (|mask[8*i +: 8]);
    end

endmodule

// File: rtl/umerge_unit.sv
// Partial-word load/store byte merger with one registered response stage.
// Assumes inputs are known while req_vld is high; outputs clear when idle.
module umerge_unit
    import umerge_pkg::*;
#(
    parameter  int DATA_W = 64,
    parameter  int ADDR_W = 32,
    localparam int NB     = DATA_W / 8,
    localparam int OFS_W  = $clog2(NB),
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [1:0]        req_op,
    input  logic              req_dword,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_mem,
    input  logic [DATA_W-1:0] req_reg,
    output logic              rsp_vld,
    output logic [DATA_W-1:0] rsp_reg,
    output logic [DATA_W-1:0] rsp_wdata,
    output logic [NB-1:0]     rsp_be,
    output logic [ADDR_W-1:0] rsp_addr
);

    merge_op_e         op;
    logic              is_store;
    logic [OFS_W-1:0]  size_m1;
    logic [SH_W-1:0]   shift_amt;
    logic              to_left;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] merge_mask;
    logic [DATA_W-1:0] keep_val;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] result;
    logic [NB-1:0]     be;
    logic [ADDR_W-1:0] aligned;

    // Decode the operation and choose which operand is kept and which moves.
    always_comb begin
        op       = merge_op_e'(req_op);
        is_store = op_is_store(op);
        keep_val = is_store ? req_mem : req_reg;
        src_val  = is_store ? req_reg : req_mem;
        aligned  = req_addr & ~ADDR_W'(size_m1);
    end

    umerge_lane_ctl #(.DATA_W(DATA_W)) u_ctl (
        .op         (op),
        .dword      (req_dword),
        .ofs        (req_addr[OFS_W-1:0]),
        .size_m1    (size_m1),
        .shift_amt  (shift_amt),
        .to_left    (to_left),
        .lane_mask  (lane_mask),
        .merge_mask (merge_mask)
    );

    umerge_datapath #(.DATA_W(DATA_W)) u_dp (
        .keep_val   (keep_val),
        .src_val    (src_val),
        .lane_mask  (lane_mask),
        .merge_mask (merge_mask),
        .shift_amt  (shift_amt),
        .to_left    (to_left),
        .sext_word  (!is_store && !req_dword),
        .result     (result)
    );

    umerge_byte_en #(.DATA_W(DATA_W)) u_be (
        .enable (is_store),
        .mask   (merge_mask),
        .be     (be)
    );

    // Response register: cleared on reset and on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_vld) begin
            rsp_vld   <= 1'b0;
            rsp_reg   <= '0;
            rsp_wdata <= '0;
            rsp_be    <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_vld   <= 1'b1;
            rsp_reg   <= is_store ? '0 : result;
            rsp_wdata <= is_store ? result : '0;
            rsp_be    <= be;
            rsp_addr  <= aligned;
        end
    end

endmodule

// File: rtl/umerge_unit_chk.sv
// Property checker for umerge_unit, bound to every instance.
// Assumes reset is asserted from time zero.
module umerge_unit_chk #(
    parameter  int DATA_W = 64,
    parameter  int ADDR_W = 32,
    localparam int NB     = DATA_W / 8,
    localparam int OFS_W  = $clog2(NB),
    localparam int HALF   = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic [1:0]        req_op,
    input logic              req_dword,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_vld,
    input logic [DATA_W-1:0] rsp_reg,
    input logic [DATA_W-1:0] rsp_wdata,
    input logic [NB-1:0]     rsp_be,
    input logic [ADDR_W-1:0] rsp_addr
);

    p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && rsp_be == '0));

    p_dword_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_dword) |=> (rsp_addr[OFS_W-1:0] == '0));

    p_word_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_dword) |=> (rsp_addr[OFS_W-2:0] == '0));

    p_word_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_dword && !req_op[1]) |=>
        (rsp_reg[DATA_W-1:HALF] == {HALF{rsp_reg[HALF-1]}}));

    p_load_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_op[1]) |=> (rsp_be == '0 && rsp_wdata == '0));

    p_store_no_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op[1]) |=> (rsp_reg == '0));

    p_word_store_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op[1] && !req_dword) |=>
        (rsp_be[NB-1:NB/2] == '0 && rsp_wdata[DATA_W-1:HALF] == '0));

    p_store_left_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'b10 && req_dword) |=>
        ($countones(rsp_be) == NB - int'($past(req_addr[OFS_W-1:0]))));

    p_store_right_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'b11 && req_dword) |=>
        ($countones(rsp_be) == int'($past(req_addr[OFS_W-1:0])) + 1));

endmodule

bind umerge_unit umerge_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_op    (req_op),
    .req_dword (req_dword),
    .req_addr  (req_addr),
    .rsp_vld   (rsp_vld),
    .rsp_reg   (rsp_reg),
    .rsp_wdata (rsp_wdata),
    .rsp_be    (rsp_be),
    .rsp_addr  (rsp_addr)
);

// File: tb/umerge_unit_test.sv
// Self-checking bench: byte-by-byte behavioural model, compared every clock.
module umerge_unit_test;

    localparam int DATA_W = 64;
    localparam int ADDR_W = 32;
    localparam int NB     = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_vld;
    logic [1:0]        req_op;
    logic              req_dword;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_mem;
    logic [DATA_W-1:0] req_reg;
    logic              rsp_vld;
    logic [DATA_W-1:0] rsp_reg;
    logic [DATA_W-1:0] rsp_wdata;
    logic [NB-1:0]     rsp_be;
    logic [ADDR_W-1:0] rsp_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic              e_vld;
    logic [DATA_W-1:0] e_reg;
    logic [DATA_W-1:0] e_wd;
    logic [NB-1:0]     e_be;
    logic [ADDR_W-1:0] e_addr;
    string             e_tag;

    always #2 clk = ~clk;

    umerge_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (req_vld),
        .req_op    (req_op),
        .req_dword (req_dword),
        .req_addr  (req_addr),
        .req_mem   (req_mem),
        .req_reg   (req_reg),
        .rsp_vld   (rsp_vld),
        .rsp_reg   (rsp_reg),
        .rsp_wdata (rsp_wdata),
        .rsp_be    (rsp_be),
        .rsp_addr  (rsp_addr)
    );

    // Reference: moves bytes one at a time in big-endian order.
    function automatic void ref_model(input int op, input bit dw, input logic [31:0] addr,
                                      input logic [63:0] mem, input logic [63:0] regv,
                                      output logic [63:0] o_reg, output logic [63:0] o_wd,
                                      output logic [7:0] o_be, output logic [31:0] o_addr);
        int sz;
        int o;
        int sh;
        bit st;
        logic [63:0] res;
        logic [7:0] be;
        sz = dw ? 8 : 4;
        o  = int'(addr) % sz;
        if (o < 0) o = o + sz;
        o  = int'(addr[2:0]) % sz;
        sh = sz - 1 - o;
        st = (op >= 2);
        be = 8'h00;
        res = st ? mem : regv;
        if (!dw) res[63:32] = 32'h0;
        for (int k = 0; k < sz; k++) begin
            int dl;
            dl = 8 * (sz - 1 - k);
            case (op)
                0: if (k < sz - o) res[dl +: 8] = mem[8 * (sz - 1 - (k + o)) +: 8];
                1: if (k >= sh) res[dl +: 8] = mem[8 * (sz - 1 - (k - sh)) +: 8];
                2: if (k >= o) begin
                       res[dl +: 8] = regv[8 * (sz - 1 - (k - o)) +: 8];
                       be[sz - 1 - k] = 1'b1;
                   end
                default: if (k <= o) begin
                       res[dl +: 8] = regv[8 * (sz - 1 - (k + sh)) +: 8];
                       be[sz - 1 - k] = 1'b1;
                   end
            endcase
        end
        if (!st && !dw) res[63:32] = {32{res[31]}};
        o_reg  = st ? 64'h0 : res;
        o_wd   = st ? res : 64'h0;
        o_be   = be;
        o_addr = addr & ~32'(sz - 1);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Compare every output against the expectation for the previous cycle.
    task automatic compare_all();
        chk({e_tag, " R9 vld"}, 64'(rsp_vld), 64'(e_vld));
        chk({e_tag, " R1 addr"}, 64'(rsp_addr), 64'(e_addr));
        chk({e_tag, " reg"}, rsp_reg, e_reg);
        chk({e_tag, " R8 wdata"}, rsp_wdata, e_wd);
        chk({e_tag, " R7 be"}, 64'(rsp_be), 64'(e_be));
    endtask

    // Drive one cycle at the falling edge and check the response a cycle later.
    task automatic step(input bit v, input int op, input bit dw, input logic [31:0] addr,
                        input logic [63:0] mem, input logic [63:0] regv);
        req_vld   = v;
        req_op    = 2'(op);
        req_dword = dw;
        req_addr  = addr;
        req_mem   = mem;
        req_reg   = regv;
        if (v && rst_n) begin
            e_vld = 1'b1;
            ref_model(op, dw, addr, mem, regv, e_reg, e_wd, e_be, e_addr);
            case (op)
                0: e_tag = "R2 load-left";
                1: e_tag = "R3 load-right";
                2: e_tag = "R4 store-left";
                default: e_tag = "R5 store-right";
            endcase
            if (!dw) e_tag = {e_tag, (op < 2) ? " word R6 R10" : " word R7 R10"};
        end else begin
            e_vld = 1'b0; e_reg = '0; e_wd = '0; e_be = '0; e_addr = '0;
            e_tag = "R9 idle/reset";
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        rst_n = 1'b0;
        req_vld = 1'b0; req_op = 2'b00; req_dword = 1'b0;
        req_addr = '0; req_mem = '0; req_reg = '0;
        @(negedge clk);
        step(1'b1, 0, 1'b1, 32'h1234_5671, 64'h0011_2233_4455_6677, 64'h8899_aabb_ccdd_eeff);
        step(1'b0, 0, 1'b0, 32'h0, 64'h0, 64'h0);
        rst_n = 1'b1;
        step(1'b0, 0, 1'b0, 32'h0, 64'h0, 64'h0);
        for (int p = 0; p < 3; p++) begin
            for (int op = 0; op < 4; op++) begin
                for (int dw = 0; dw < 2; dw++) begin
                    for (int o = 0; o < (dw ? 8 : 4); o++) begin
                        logic [63:0] m;
                        logic [63:0] r;
                        logic [31:0] a;
                        case (p)
                            0: begin m = 64'h0011_2233_4455_6677; r = 64'h8899_aabb_ccdd_eeff; end
                            1: begin m = {$urandom, $urandom}; r = {$urandom, $urandom}; end
                            default: begin m = 64'hffff_ffff_ffff_ffff; r = 64'h0; end
                        endcase
                        if (!dw) begin
                            m[63:32] = $urandom;
                            r[63:32] = $urandom;
                            if (p == 2) m[31] = 1'b1;
                            a = ($urandom & ~32'h3) | 32'(o);
                        end else begin
                            a = ($urandom & ~32'h7) | 32'(o);
                        end
                        step(1'b1, op, bit'(dw), a, m, r);
                        if (o == 2) step(1'b0, 0, 1'b0, 32'h0, 64'h0, 64'h0);
                    end
                end
            end
        end
        // Reset in the middle of traffic must clear the response (R9).
        rst_n = 1'b0;
        step(1'b1, 3, 1'b1, 32'h0000_0005, 64'h1, 64'h2);
        rst_n = 1'b1;
        step(1'b1, 1, 1'b0, 32'h0000_0002, 64'hdead_beef_8765_4321, 64'h0123_4567_89ab_cdef);
        step(1'b0, 0, 1'b0, 32'h0, 64'h0, 64'h0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule